// File: doc/BRIEF.md
# Configurable Binary/Ternary Row Matcher

This block compares one search key against every entry of a single memory row in parallel. Each entry carries a stored key, a stored mask of the same width, a data field and a valid bit. A per-bit comparator either demands equality or, when that bit position is set to ternary, treats a set mask bit as a wildcard. Bit positions outside the active key window take no part in the compare. This lets one block serve exact-match tables and masked-prefix tables of different key lengths.

The block has two stages. The first stage spreads the search key across all entries and forms a per-entry match vector, which is then registered. The second stage picks the lowest-numbered matching entry, extracts that entry's data, and registers the result. A lookup can enter on every clock cycle, and each result appears a fixed two cycles after its request.

Top module: `rowmatch_row`

## Requirements
- R1: With a bit position active (`cfg_key_en[b]`=1) and in binary mode (`cfg_tern_en[b]`=0), an entry matches at that bit only when its stored key bit equals the search bit. In binary mode the stored mask bit has no effect.
- R2: With a bit position active and in ternary mode (`cfg_tern_en[b]`=1), a stored mask bit of 1 makes that bit match whatever the search bit is. A mask bit of 0 demands equality.
- R3: A bit position with `cfg_key_en[b]`=0 is ignored and always matches. This holds in both modes.
- R4: An entry whose `row_valid[i]` is 0 never matches. This holds even when every bit is masked or disabled.
- R5: `match_vec[i]` is 1 exactly when entry i matches on all bit positions. `hit` is 1 exactly when any bit of `match_vec` is set.
- R6: `hit_idx` is the lowest index i with `match_vec[i]`=1.
- R7: On a hit, `hit_data` equals the data field of the winning entry, which is held in bits [i*DATA_W +: DATA_W] of `row_data`. On a miss, `hit`=0, `hit_idx`=0 and `hit_data`=0.
- R8: A request presented with `in_valid` at clock edge k produces its result with `out_valid`=1 after edge k+2. A cycle with `in_valid`=0 gives `out_valid`=0 two edges later. A lookup can be accepted on every cycle.
- R9: While `rst_n` is low, `out_valid`, `hit`, `hit_idx`, `match_vec` and `hit_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lookup request present |
| search_key | input | KEY_W | Key to search for |
| cfg_key_en | input | KEY_W | Per-bit active-window select |
| cfg_tern_en | input | KEY_W | Per-bit ternary mode select |
| row_key | input | NUM_ENT*KEY_W | Stored keys, entry i in [i*KEY_W +: KEY_W] |
| row_mask | input | NUM_ENT*KEY_W | Stored masks (1 = wildcard in ternary mode) |
| row_data | input | NUM_ENT*DATA_W | Stored data fields |
| row_valid | input | NUM_ENT | Per-entry valid bits |
| out_valid | output | 1 | Result present |
| match_vec | output | NUM_ENT | Per-entry match results |
| hit | output | 1 | At least one entry matched |
| hit_idx | output | IDX_W | Index of the lowest matching entry |
| hit_data | output | DATA_W | Data of the winning entry, or 0 on a miss |

## Verification
Two pieces of work overlap in the same cycle. A new compare in stage one, possibly under a freshly changed configuration, runs while the previous lookup is decoded and extracted in stage two. The bench streams lookups back to back and changes the key window, the ternary select and the valid pattern between groups. Every output is judged against a model that is kept two cycles behind the inputs. Within one lookup, several entries often match together: a wildcard entry, a fully disabled window and partial masks all hit at once. The bench checks that the lowest valid index wins and that its data is the one extracted.

// File: rtl/rowmatch_pkg.sv
package rowmatch_pkg;

    typedef enum logic {
        CMP_BINARY  = 1'b0,
        CMP_TERNARY = 1'b1
    } cmp_mode_e;

endpackage

// File: rtl/rowmatch_entry_cmp.sv
module rowmatch_entry_cmp
    import rowmatch_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic [KEY_W-1:0] search_key,
    input  logic [KEY_W-1:0] ent_key,
    input  logic [KEY_W-1:0] ent_mask,
    input  logic             ent_valid,
    input  logic [KEY_W-1:0] key_en,
    input  logic [KEY_W-1:0] tern_en,
    output logic             ent_hit
);

    logic [KEY_W-1:0] bit_ok;

    for (genvar b = 0; b < KEY_W; b++) begin : g_bit
        logic      same_b;
        logic      masked_b;
        cmp_mode_e mode_b;

        assign same_b   = ~(search_key[b] ^ ent_key[b]);
        assign masked_b = same_b | ent_mask[b];
        assign mode_b   = tern_en[b] ? CMP_TERNARY : CMP_BINARY;

        always_comb begin
            case (mode_b)
                CMP_TERNARY: bit_ok[b] = masked_b | ~key_en[b];
                default:     bit_ok[b] = same_b   | ~key_en[b];
            endcase
        end
    end

    assign ent_hit = ent_valid & (&bit_ok);

endmodule

// File: rtl/rowmatch_prio.sv
module rowmatch_prio #(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_ENT-1:0] req_vec,
    output logic               found,
    output logic [IDX_W-1:0]   win_idx
);

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rowmatch_row.sv
module rowmatch_row #(
    parameter int NUM_ENT = 4,
    parameter int KEY_W   = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [KEY_W-1:0]          search_key,
    input  logic [KEY_W-1:0]          cfg_key_en,
    input  logic [KEY_W-1:0]          cfg_tern_en,
    input  logic [NUM_ENT*KEY_W-1:0]  row_key,
    input  logic [NUM_ENT*KEY_W-1:0]  row_mask,
    input  logic [NUM_ENT*DATA_W-1:0] row_data,
    input  logic [NUM_ENT-1:0]        row_valid,
    output logic                      out_valid,
    output logic [NUM_ENT-1:0]        match_vec,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx,
    output logic [DATA_W-1:0]         hit_data
);

    typedef struct packed {
        logic                      vld;
        logic [NUM_ENT-1:0]        vec;
        logic [NUM_ENT*DATA_W-1:0] data;
    } cmp_stage_t;

    typedef struct packed {
        logic               vld;
        logic [NUM_ENT-1:0] vec;
        logic               hit;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  data;
    } res_stage_t;

    typedef struct packed {
        cmp_stage_t s1;
        res_stage_t s2;
    } pipe_t;

    pipe_t              pipe_d, pipe_q;
    logic [NUM_ENT-1:0] cmp_vec;
    logic               prio_found;
    logic [IDX_W-1:0]   prio_idx;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        rowmatch_entry_cmp #(.KEY_W(KEY_W)) u_cmp (
            .search_key (search_key),
            .ent_key    (row_key[i*KEY_W +: KEY_W]),
            .ent_mask   (row_mask[i*KEY_W +: KEY_W]),
            .ent_valid  (row_valid[i]),
            .key_en     (cfg_key_en),
            .tern_en    (cfg_tern_en),
            .ent_hit    (cmp_vec[i])
        );
    end

    rowmatch_prio #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_prio (
        .req_vec (pipe_q.s1.vec),
        .found   (prio_found),
        .win_idx (prio_idx)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s1.vld  = in_valid;
        pipe_d.s1.vec  = cmp_vec;
        pipe_d.s1.data = row_data;
        pipe_d.s2.vld  = pipe_q.s1.vld;
        pipe_d.s2.vec  = pipe_q.s1.vec;
        pipe_d.s2.hit  = prio_found;
        pipe_d.s2.idx  = prio_idx;
        pipe_d.s2.data = prio_found ? pipe_q.s1.data[prio_idx*DATA_W +: DATA_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s2.vld;
    assign match_vec = pipe_q.s2.vec;
    assign hit       = pipe_q.s2.hit;
    assign hit_idx   = pipe_q.s2.idx;
    assign hit_data  = pipe_q.s2.data;

    logic [NUM_ENT-1:0] below_win;
    assign below_win = match_vec & ((NUM_ENT'(1) << hit_idx) - NUM_ENT'(1));

    assert_lat_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    assert_lat_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);
    assert_any_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (|match_vec));
    assert_win_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_idx]);
    assert_lower_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (below_win == '0));
    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_data == '0 && hit_idx == '0));

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_chk
        assert_invalid_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !row_valid[i] |=> !pipe_q.s1.vec[i]);
    end

endmodule

// File: tb/rowmatch_row_tb_top.sv
module rowmatch_row_tb_top;

    localparam int N  = 4;
    localparam int KW = 4;
    localparam int DW = 8;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [KW-1:0]   search_key = '0;
    logic [KW-1:0]   cfg_key_en = '0;
    logic [KW-1:0]   cfg_tern_en = '0;
    logic [N*KW-1:0] row_key = '0;
    logic [N*KW-1:0] row_mask = '0;
    logic [N*DW-1:0] row_data = '0;
    logic [N-1:0]    row_valid = '0;
    logic            out_valid;
    logic [N-1:0]    match_vec;
    logic            hit;
    logic [IW-1:0]   hit_idx;
    logic [DW-1:0]   hit_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rowmatch_row #(.NUM_ENT(N), .KEY_W(KW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .search_key(search_key),
        .cfg_key_en(cfg_key_en), .cfg_tern_en(cfg_tern_en), .row_key(row_key),
        .row_mask(row_mask), .row_data(row_data), .row_valid(row_valid),
        .out_valid(out_valid), .match_vec(match_vec), .hit(hit),
        .hit_idx(hit_idx), .hit_data(hit_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of R1 R2 R3 R4: per-bit rules, then AND across bits
    function automatic logic [N-1:0] model_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            v[i] = row_valid[i];
            for (int b = 0; b < KW; b++) begin
                if (cfg_key_en[b] && !(cfg_tern_en[b] && row_mask[i*KW+b]) &&
                    (row_key[i*KW+b] != search_key[b]))
                    v[i] = 1'b0;
            end
        end
        return v;
    endfunction

    logic [N-1:0]  ev   [2];
    logic          evld [2];
    logic          pv   [2];
    logic [N-1:0]  rv   [2];

    task automatic check_out();
        int widx;
        check("R8 out_valid", out_valid, evld[1]);
        if (!evld[1]) return;
        check("R1/R2/R3 match_vec", match_vec, ev[1]);
        for (int i = 0; i < N; i++)
            if (!rv[1][i]) check("R4 invalid entry", match_vec[i], 0);
        check("R5 hit", hit, |ev[1]);
        widx = 0;
        for (int i = N - 1; i >= 0; i--) if (ev[1][i]) widx = i;
        check("R6 hit_idx", hit_idx, widx);
        check("R7 hit_data", hit_data, (|ev[1]) ? 8'h11 * (widx + 1) : 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            row_key[i*KW +: KW]  = KW'(i * 5);
            row_data[i*DW +: DW] = DW'(8'h11 * (i + 1));
        end
        row_mask = {4'b1111, 4'b1000, 4'b0011, 4'b0000};
        evld[0] = 0; evld[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset out_valid", out_valid, 0);
        check("R9 reset hit", hit, 0);
        check("R9 reset match_vec", match_vec, 0);
        check("R9 reset hit_data", hit_data, 0);
        check("R9 reset hit_idx", hit_idx, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k <= 16; k++) begin
                @(negedge clk);
                check_out();
                cfg_key_en  = (c[1:0] == 0) ? 4'hF : (c[1:0] == 1) ? 4'h7 :
                              (c[1:0] == 2) ? 4'h3 : 4'h0;
                cfg_tern_en = c[2] ? 4'hF : 4'h5;
                row_valid   = c[3] ? 4'b0110 : 4'b1111;
                search_key  = KW'(k);
                in_valid    = (k != 16);
                ev[1] = ev[0]; evld[1] = evld[0]; rv[1] = rv[0];
                ev[0] = model_vec(); evld[0] = in_valid; rv[0] = row_valid;
            end
        end
        in_valid = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check_out();
            ev[1] = ev[0]; evld[1] = evld[0]; rv[1] = rv[0];
            evld[0] = 0;
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule